// File: doc/BRIEF.md
# Circular Drop-Log Ring Writer

This block stores fixed-size records that describe dropped packets into a circular window of memory. Software picks the window with a lower and an upper address register. The block owns a hardware write pointer, and software owns a read pointer. When the filter raises a log request, the block copies the four-word record it carries and emits it as four consecutive word writes on a plain memory write port. It then moves the write pointer forward by one record, wrapping to the lower address when the upper address is reached.

The upper address is a look-ahead value: it names the word just past the last usable word. Software signals that its own reads have wrapped by writing the upper address into its read pointer. The block treats that value as the lower address. One record slot is always kept free, so that a full ring can be told apart from an empty one. When the ring is full, a control bit chooses the outcome. Either the new record is discarded, or it is written anyway and the read pointer is pushed past the oldest record.

Top module: `droplog_ring_writer`

## Requirements
- R1: After reset the lower address reads 0, the upper address reads 0x00001000, both pointers read 0, `busy` is low and no memory write is issued.
- R2: While `log_en` is low, a request is discarded: no memory write is issued and neither pointer changes.
- R3: An accepted request produces exactly four word writes, one in each of the four cycles after the accepting clock edge. Their addresses are P, P+4, P+8 and P+12, where P is the write pointer at acceptance. Write i carries `req_rec[32*i+31:32*i]`, and `busy` is high in exactly those four cycles.
- R4: The write pointer changes only on the clock edge that ends the fourth write of a record. At that edge it becomes P+16, or the lower address if P+16 is at or above the upper address.
- R5: A register write with select 0 loads the lower address, and also loads both pointers with the same value, so the next record is written starting at the lower address.
- R6: The ring is full when the advanced write pointer (as in R4) equals the effective read pointer. With `ovw_en` low, a request that arrives while the ring is full is discarded, with no write and no pointer change.
- R7: A read pointer equal to the upper address is treated as the lower address in the full test of R6.
- R8: With `ovw_en` high, a request that arrives while the ring is full is accepted and written at the write pointer. On the accepting edge the read pointer moves to the effective read pointer plus 16, wrapping as in R4.
- R9: A request that arrives while `busy` is high is ignored, and a new request can be accepted only after `busy` has been low for a full cycle.
- R10: A register write with select 1 loads the upper address, select 2 loads the write pointer and select 3 loads the read pointer. Each new value is visible on its output in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| log_en | input | 1 | Logging enable |
| ovw_en | input | 1 | Overwrite enable used when the ring is full |
| req_valid | input | 1 | Log request strobe |
| req_rec | input | 128 | Record to log, word 0 in the low bits |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select: 0 lower, 1 upper, 2 write pointer, 3 read pointer |
| reg_wr_data | input | 32 | Register write value |
| region_begin | output | 32 | Lower address of the ring |
| region_end | output | 32 | Upper (look-ahead) address of the ring |
| hw_ptr | output | 32 | Next address the block will write |
| sw_ptr | output | 32 | Next address software will read |
| busy | output | 1 | A record is being written |
| mem_wr_en | output | 1 | Memory word write strobe |
| mem_wr_addr | output | 32 | Memory word byte address |
| mem_wr_data | output | 32 | Memory word data |

## Verification
Some properties are checked on every cycle. Every burst is exactly four words long, and each address in a burst is four above the one before. The write pointer moves only when a burst ends, and then either by one record or back to the lower address. No burst starts while logging is disabled, or while the ring is full and overwrite is off. The read pointer moves by itself only under overwrite. Only the bench's scenarios can show the rest: that the addresses land on the right slots, that the record words appear in order, that wrapping happens at the look-ahead upper address, that the upper-address read pointer is folded onto the lower address, and that the exact slot is sacrificed when overwriting. For this the bench walks a four-record ring through filling, draining, wrap and overwrite.

// File: rtl/droplog_pkg.sv
package droplog_pkg;

    typedef enum logic [1:0] {
        RSEL_LO = 2'd0,
        RSEL_HI = 2'd1,
        RSEL_HW = 2'd2,
        RSEL_SW = 2'd3
    } dlog_rsel_e;

    localparam logic [31:0] HI_RESET = 32'h0000_1000;

endpackage

// File: rtl/dlog_wrap_adv.sv
module dlog_wrap_adv #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 16
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W:0] sum;

    always_comb begin
        sum = {1'b0, ptr} + (ADDR_W+1)'(STEP);
        if (sum >= {1'b0, hi}) begin
            nxt = lo;
        end else begin
            nxt = sum[ADDR_W-1:0];
        end
    end
endmodule

// File: rtl/dlog_space_calc.sv
module dlog_space_calc #(
    parameter int ADDR_W    = 32,
    parameter int REC_BYTES = 16
) (
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    input  logic [ADDR_W-1:0] hw,
    input  logic [ADDR_W-1:0] sw,
    output logic [ADDR_W-1:0] hw_adv,
    output logic [ADDR_W-1:0] sw_adv,
    output logic              full
);
    localparam int NPTR = 2;

    logic [ADDR_W-1:0] sw_eff;
    logic [ADDR_W-1:0] src [NPTR];
    logic [ADDR_W-1:0] adv [NPTR];

    // a read pointer parked on the upper address means software has wrapped
    assign sw_eff = (sw == hi) ? lo : sw;
    assign src[0] = hw;
    assign src[1] = sw_eff;

    for (genvar g = 0; g < NPTR; g++) begin : g_adv
        dlog_wrap_adv #(
            .ADDR_W (ADDR_W),
            .STEP   (REC_BYTES)
        ) u_adv (
            .ptr (src[g]),
            .lo  (lo),
            .hi  (hi),
            .nxt (adv[g])
        );
    end

    assign hw_adv = adv[0];
    assign sw_adv = adv[1];
    // one slot stays empty: full when the next write slot would reach the reader
    assign full   = (adv[0] == sw_eff);
endmodule

// File: rtl/dlog_ptr_regs.sv
module dlog_ptr_regs
    import droplog_pkg::*;
#(
    parameter int          ADDR_W = 32,
    parameter logic [31:0] HI_RST = HI_RESET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_sel,
    input  logic [ADDR_W-1:0] reg_wr_data,
    input  logic              hw_adv_en,
    input  logic [ADDR_W-1:0] hw_adv_val,
    input  logic              sw_push_en,
    input  logic [ADDR_W-1:0] sw_push_val,
    output logic [ADDR_W-1:0] lo_addr,
    output logic [ADDR_W-1:0] hi_addr,
    output logic [ADDR_W-1:0] hw_ptr,
    output logic [ADDR_W-1:0] sw_ptr
);
    typedef struct packed {
        logic [ADDR_W-1:0] lo_a;
        logic [ADDR_W-1:0] hi_a;
        logic [ADDR_W-1:0] hw;
        logic [ADDR_W-1:0] sw;
    } ptr_st_t;

    ptr_st_t    st_d, st_q;
    dlog_rsel_e sel;

    assign sel = dlog_rsel_e'(reg_wr_sel);

    always_comb begin
        st_d = st_q;
        // hardware updates first, a software write of the same field wins
        if (hw_adv_en) begin
            st_d.hw = hw_adv_val;
        end
        if (sw_push_en) begin
            st_d.sw = sw_push_val;
        end
        if (reg_wr_en) begin
            case (sel)
                RSEL_LO: begin
                    st_d.lo_a = reg_wr_data;
                    st_d.hw   = reg_wr_data;
                    st_d.sw   = reg_wr_data;
                end
                RSEL_HI: st_d.hi_a = reg_wr_data;
                RSEL_HW: st_d.hw   = reg_wr_data;
                RSEL_SW: st_d.sw   = reg_wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lo_a <= '0;
            st_q.hi_a <= ADDR_W'(HI_RST);
            st_q.hw   <= '0;
            st_q.sw   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lo_addr = st_q.lo_a;
    assign hi_addr = st_q.hi_a;
    assign hw_ptr  = st_q.hw;
    assign sw_ptr  = st_q.sw;
endmodule

// File: rtl/dlog_burst.sv
module dlog_burst #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [ADDR_W-1:0]       start_addr,
    input  logic [WORDS*DATA_W-1:0] start_rec,
    output logic                    busy,
    output logic                    last,
    output logic                    mem_wr_en,
    output logic [ADDR_W-1:0]       mem_wr_addr,
    output logic [DATA_W-1:0]       mem_wr_data
);
    localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int REC_W  = WORDS * DATA_W;
    localparam int OFF_SH = $clog2(DATA_W / 8);

    typedef struct packed {
        logic              active;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] base;
        logic [REC_W-1:0]  rec;
    } burst_st_t;

    burst_st_t st_d, st_q;
    logic      last_w;

    assign last_w = st_q.active && (st_q.idx == IDX_W'(WORDS - 1));

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.active = 1'b1;
            st_d.idx    = '0;
            st_d.base   = start_addr;
            st_d.rec    = start_rec;
        end else if (st_q.active) begin
            if (last_w) begin
                st_d.active = 1'b0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy        = st_q.active;
    assign last        = last_w;
    assign mem_wr_en   = st_q.active;
    assign mem_wr_addr = st_q.base + (ADDR_W'(st_q.idx) << OFF_SH);
    assign mem_wr_data = st_q.rec[st_q.idx*DATA_W +: DATA_W];
endmodule

// File: rtl/droplog_ring_writer.sv
module droplog_ring_writer
    import droplog_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter int          REC_WORDS = 4,
    parameter logic [31:0] HI_RST    = HI_RESET
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        log_en,
    input  logic                        ovw_en,
    input  logic                        req_valid,
    input  logic [REC_WORDS*DATA_W-1:0] req_rec,
    input  logic                        reg_wr_en,
    input  logic [1:0]                  reg_wr_sel,
    input  logic [ADDR_W-1:0]           reg_wr_data,
    output logic [ADDR_W-1:0]           region_begin,
    output logic [ADDR_W-1:0]           region_end,
    output logic [ADDR_W-1:0]           hw_ptr,
    output logic [ADDR_W-1:0]           sw_ptr,
    output logic                        busy,
    output logic                        mem_wr_en,
    output logic [ADDR_W-1:0]           mem_wr_addr,
    output logic [DATA_W-1:0]           mem_wr_data
);
    localparam int REC_BYTES = REC_WORDS * (DATA_W / 8);

    logic [ADDR_W-1:0] hw_adv, sw_adv;
    logic              full_w;
    logic              busy_w, last_w;
    logic              accept, ovw_take;

    // a request is taken only when idle, enabled, and space exists or overwrite is on
    assign accept   = req_valid && log_en && !busy_w && (!full_w || ovw_en);
    assign ovw_take = accept && full_w;

    dlog_space_calc #(
        .ADDR_W    (ADDR_W),
        .REC_BYTES (REC_BYTES)
    ) u_space (
        .lo     (region_begin),
        .hi     (region_end),
        .hw     (hw_ptr),
        .sw     (sw_ptr),
        .hw_adv (hw_adv),
        .sw_adv (sw_adv),
        .full   (full_w)
    );

    dlog_ptr_regs #(
        .ADDR_W (ADDR_W),
        .HI_RST (HI_RST)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_sel  (reg_wr_sel),
        .reg_wr_data (reg_wr_data),
        .hw_adv_en   (last_w),
        .hw_adv_val  (hw_adv),
        .sw_push_en  (ovw_take),
        .sw_push_val (sw_adv),
        .lo_addr     (region_begin),
        .hi_addr     (region_end),
        .hw_ptr      (hw_ptr),
        .sw_ptr      (sw_ptr)
    );

    dlog_burst #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WORDS  (REC_WORDS)
    ) u_burst (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .start_addr  (hw_ptr),
        .start_rec   (req_rec),
        .busy        (busy_w),
        .last        (last_w),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data)
    );

    assign busy = busy_w;
endmodule

// File: rtl/droplog_ring_writer_chk.sv
module droplog_ring_writer_chk #(
    parameter int ADDR_W    = 32,
    parameter int REC_WORDS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              log_en,
    input logic              ovw_en,
    input logic              reg_wr_en,
    input logic              busy,
    input logic              full_w,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [ADDR_W-1:0] hw_ptr,
    input logic [ADDR_W-1:0] sw_ptr,
    input logic [ADDR_W-1:0] region_begin
);
    localparam int RUN_W     = $clog2(REC_WORDS) + 2;
    localparam int REC_BYTES = REC_WORDS * 4;

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (mem_wr_en) begin
            if (run_q != {RUN_W{1'b1}}) run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    // R3: every burst holds exactly one record of words
    p_burst_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_en && $past(mem_wr_en)) |-> (run_q == RUN_W'(REC_WORDS)));

    // R3: addresses inside a burst step one word at a time
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && $past(mem_wr_en)) |-> (mem_wr_addr == $past(mem_wr_addr) + ADDR_W'(4)));

    // R4: the write pointer moves only as a burst ends
    p_hw_when_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(hw_ptr) && !$past(reg_wr_en)) |-> ($past(busy) && !busy));

    // R4: it moves by one record or back to the lower address
    p_hw_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(hw_ptr) && !$past(reg_wr_en)) |->
        ((hw_ptr == $past(hw_ptr) + ADDR_W'(REC_BYTES)) || (hw_ptr == region_begin)));

    // R2: nothing starts while logging is off
    p_no_start_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !log_en) |=> !busy);

    // R6: a full ring with overwrite off starts nothing
    p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && full_w && !ovw_en) |=> !busy);

    // R8: the read pointer moves by itself only under overwrite
    p_sw_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sw_ptr) && !$past(reg_wr_en)) |-> ($past(ovw_en) && busy && !$past(busy)));
endmodule

bind droplog_ring_writer droplog_ring_writer_chk #(
    .ADDR_W    (ADDR_W),
    .REC_WORDS (REC_WORDS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .log_en       (log_en),
    .ovw_en       (ovw_en),
    .reg_wr_en    (reg_wr_en),
    .busy         (busy),
    .full_w       (full_w),
    .mem_wr_en    (mem_wr_en),
    .mem_wr_addr  (mem_wr_addr),
    .hw_ptr       (hw_ptr),
    .sw_ptr       (sw_ptr),
    .region_begin (region_begin)
);

// File: tb/droplog_ring_writer_tb.sv
`timescale 1ns/1ps
module droplog_ring_writer_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         log_en = 1'b0;
    logic         ovw_en = 1'b0;
    logic         req_valid = 1'b0;
    logic [127:0] req_rec = '0;
    logic         reg_wr_en = 1'b0;
    logic [1:0]   reg_wr_sel = '0;
    logic [31:0]  reg_wr_data = '0;
    logic [31:0]  region_begin, region_end, hw_ptr, sw_ptr;
    logic         busy, mem_wr_en;
    logic [31:0]  mem_wr_addr, mem_wr_data;

    droplog_ring_writer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .log_en       (log_en),
        .ovw_en       (ovw_en),
        .req_valid    (req_valid),
        .req_rec      (req_rec),
        .reg_wr_en    (reg_wr_en),
        .reg_wr_sel   (reg_wr_sel),
        .reg_wr_data  (reg_wr_data),
        .region_begin (region_begin),
        .region_end   (region_end),
        .hw_ptr       (hw_ptr),
        .sw_ptr       (sw_ptr),
        .busy         (busy),
        .mem_wr_en    (mem_wr_en),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data)
    );

    always #2 clk = ~clk;

    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // ---------------- behavioural reference model ----------------
    typedef struct packed {
        logic [31:0] a;
        logic [31:0] d;
        logic        lst;
    } wr_t;

    wr_t         q[$];
    wr_t         cur;
    bit          cur_en = 0;
    bit          seen_edge = 0;
    logic [31:0] mb, me, mh, ms, swe, mh_pre;
    bit          mfull, acc, pre_busy;

    function automatic logic [31:0] ring_next(input logic [31:0] p,
                                              input logic [31:0] lo,
                                              input logic [31:0] hi);
        longint unsigned s;
        s = longint'(p) + 16;
        if (s >= longint'(hi)) return lo;
        return p + 32'd16;
    endfunction

    always @(posedge clk) begin
        seen_edge = 1;
        if (!rst_n) begin
            mb = 32'h0; me = 32'h1000; mh = 32'h0; ms = 32'h0;
            q.delete();
            cur_en = 0;
        end else begin
            pre_busy = cur_en;
            mh_pre   = mh;
            swe      = (ms == me) ? mb : ms;
            mfull    = (ring_next(mh, mb, me) == swe);
            acc      = req_valid && log_en && !pre_busy && (!mfull || ovw_en);
            if (cur_en && cur.lst) mh = ring_next(mh, mb, me);
            if (acc) begin
                for (int i = 0; i < 4; i++)
                    q.push_back('{a: mh_pre + 32'(4*i), d: req_rec[32*i +: 32], lst: (i == 3)});
                if (mfull) ms = ring_next(swe, mb, me);
            end
            if (reg_wr_en) begin
                case (reg_wr_sel)
                    2'd0: begin mb = reg_wr_data; mh = reg_wr_data; ms = reg_wr_data; end
                    2'd1: me = reg_wr_data;
                    2'd2: mh = reg_wr_data;
                    default: ms = reg_wr_data;
                endcase
            end
            if (q.size() > 0) begin
                cur = q.pop_front();
                cur_en = 1;
            end else begin
                cur_en = 0;
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (seen_edge) begin
            chk(cur_req, "busy", {31'b0, busy}, {31'b0, cur_en});
            chk(cur_req, "mem_wr_en", {31'b0, mem_wr_en}, {31'b0, cur_en});
            if (cur_en) begin
                chk(cur_req, "mem_wr_addr", mem_wr_addr, cur.a);
                chk(cur_req, "mem_wr_data", mem_wr_data, cur.d);
            end
            chk(cur_req, "hw_ptr", hw_ptr, mh);
            chk(cur_req, "sw_ptr", sw_ptr, ms);
            chk(cur_req, "region_begin", region_begin, mb);
            chk(cur_req, "region_end", region_end, me);
        end
    end

    task automatic report();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            report();
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic regw(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    function automatic logic [127:0] mkrec(input logic [31:0] n);
        return {n + 32'h3000_0003, n + 32'h2000_0002, n + 32'h1000_0001, n};
    endfunction

    task automatic send(input logic [31:0] n);
        @(negedge clk);
        req_valid = 1'b1; req_rec = mkrec(n);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        // R1: reset values
        cur_req = "R1";
        idle(4);
        chk("R1", "reset end", region_end, 32'h0000_1000);
        chk("R1", "reset hw", hw_ptr, 32'h0);
        chk("R1", "reset busy", {31'b0, busy}, 32'h0);
        rst_n = 1'b1;
        idle(2);

        // R2: disabled logging discards requests
        cur_req = "R2";
        send(32'hD15A_0000);
        idle(6);
        chk("R2", "hw unchanged", hw_ptr, 32'h0);

        // R5 / R10: program a four-record ring 0x100..0x140
        cur_req = "R5";
        regw(2'd0, 32'h100);
        chk("R5", "hw loaded", hw_ptr, 32'h100);
        chk("R5", "sw loaded", sw_ptr, 32'h100);
        cur_req = "R10";
        regw(2'd1, 32'h140);
        chk("R10", "end loaded", region_end, 32'h140);

        // R3 / R4: first record at begin
        cur_req = "R3";
        log_en = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_rec = mkrec(32'h0A00_0001);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3", "first addr", mem_wr_addr, 32'h100);
        chk("R3", "first data", mem_wr_data, 32'h0A00_0001);
        // R9: request during busy is ignored
        cur_req = "R9";
        send(32'h0B00_0002);
        idle(6);
        chk("R9", "one record only", hw_ptr, 32'h110);

        cur_req = "R4";
        send(32'h0C00_0003); idle(6);
        send(32'h0C00_0004); idle(6);
        chk("R4", "hw after three", hw_ptr, 32'h130);

        // R6: full with overwrite off drops
        cur_req = "R6";
        send(32'h0E00_0005); idle(6);
        chk("R6", "dropped hw", hw_ptr, 32'h130);

        // R10 / R4: software reads two records, wrap at look-ahead end
        cur_req = "R10";
        regw(2'd3, 32'h120);
        chk("R10", "sw loaded", sw_ptr, 32'h120);
        cur_req = "R4";
        send(32'h0F00_0006); idle(6);
        chk("R4", "wrap to begin", hw_ptr, 32'h100);
        send(32'h0F00_0007); idle(6);
        chk("R4", "hw after wrap", hw_ptr, 32'h110);

        // R7: sw equal to end folds onto begin
        cur_req = "R7";
        regw(2'd3, 32'h140);
        send(32'h1700_0008); idle(6);
        send(32'h1700_0009); idle(6);
        chk("R7", "hw filled", hw_ptr, 32'h130);
        send(32'h1700_000A); idle(6);
        chk("R7", "full via end-as-begin", hw_ptr, 32'h130);

        // R8: overwrite pushes the read pointer
        cur_req = "R8";
        ovw_en = 1'b1;
        send(32'h1800_000B);
        chk("R8", "sw pushed", sw_ptr, 32'h110);
        idle(6);
        chk("R8", "hw wrapped", hw_ptr, 32'h100);

        // R10: direct write-pointer load
        cur_req = "R10";
        regw(2'd2, 32'h120);
        send(32'h1900_000C);
        chk("R10", "addr from loaded hw", mem_wr_addr, 32'h120);
        idle(6);

        // R9 / R8: request held high, back-to-back records with overwrite
        cur_req = "R9";
        @(negedge clk);
        req_valid = 1'b1; req_rec = mkrec(32'h2000_0010);
        idle(16);
        req_valid = 1'b0;
        idle(8);

        // R2: disable again, nothing more happens
        cur_req = "R2";
        log_en = 1'b0;
        send(32'h2100_0011); idle(6);

        report();
        $finish;
    end
endmodule